// File: doc/BRIEF.md
# GPIO Pin Interrupt and Wake Detector

This block watches one already-debounced GPIO input and decides, every clock, whether the configured trigger condition holds. It supports two detection kinds, edge and level, chosen by a mode bit. A two-bit polarity code selects the active sense. When the condition is met it latches a sticky interrupt status and a sticky wake status. Software clears each of them by writing one.

The interrupt request is the latched status passed through a separate active-high unmask bit. Interrupt recording has its own enable. Wake recording depends only on the per-sleep-state wake enables. A pending output tells a summary stage that either status is held. Register fields arrive as plain inputs, and clears arrive as single-cycle strobes.

Top module: `gpio_pin_event`

## Requirements
- R1: After reset, `int_sts`, `wake_sts`, `irq`, `pending` and all bits of `wake_req` are 0.
- R2: With `lvl_mode`=0, polarity code 0 triggers on a rising pin edge and code 1 on a falling edge. The status is set at the first clock edge after the pin changes.
- R3: With `lvl_mode`=0, polarity code 2 triggers on both rising and falling edges.
- R4: Polarity code 3 never triggers. In level mode (`lvl_mode`=1), code 2 also never triggers.
- R5: `int_sts` is set only while `int_en`=1. A trigger seen while `int_en`=0 leaves `int_sts` at 0.
- R6: `int_sts` holds until it is cleared. `irq` is 1 exactly when `int_sts`=1 and `unmask`=1.
- R7: A pulse on `int_clr` clears `int_sts` on the next clock. If a trigger occurs in the same cycle, the status stays set.
- R8: In level mode, code 0 triggers while the pin is high and code 1 while it is low. A clear has no lasting effect while the pin stays at its active level.
- R9: `wake_sts` is set by any trigger while at least one `wake_en` bit is 1, whatever `int_en` is. `wake_clr` clears it under the same priority rule as R7. `wake_req[i]` equals `wake_sts` AND `wake_en[i]`, where bit 0 is the shallow idle state, bit 1 is suspend-to-RAM and bit 2 is hibernate/soft-off.
- R10: `pending` is 1 whenever `int_sts` or `wake_sts` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Debounced pin level |
| lvl_mode | input | 1 | 0 = edge detection, 1 = level detection |
| pol_sel | input | 2 | 0 = high/rising, 1 = low/falling, 2 = both edges, 3 = none |
| int_en | input | 1 | Allows interrupt status to be recorded |
| unmask | input | 1 | 1 = interrupt request passed to `irq` |
| wake_en | input | NUM_WAKE | Wake enable for each sleep state |
| int_clr | input | 1 | Write-one-to-clear strobe for `int_sts` |
| wake_clr | input | 1 | Write-one-to-clear strobe for `wake_sts` |
| int_sts | output | 1 | Sticky interrupt status |
| wake_sts | output | 1 | Sticky wake status |
| irq | output | 1 | Gated interrupt request |
| wake_req | output | NUM_WAKE | Wake request for each sleep state |
| pending | output | 1 | Either status held |

## Verification
Each status latch is a single flop, and every fault shows at the ports within one clock. A wrong edge reference or polarity decode shows as a status bit that stays 0, or rises when it should not, at the clock that follows the pin change. Errors in set/clear priority show as a status that is lost or survives one cycle after a clear strobe. Gating faults show at once on `irq`, `wake_req` or `pending` as a mismatch against the two latched bits.

// File: rtl/gpio_pin_event.sv
module gpio_pin_event #(
  parameter int NUM_WAKE = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pin_in,
  input  logic                lvl_mode,
  input  logic [1:0]          pol_sel,
  input  logic                int_en,
  input  logic                unmask,
  input  logic [NUM_WAKE-1:0] wake_en,
  input  logic                int_clr,
  input  logic                wake_clr,
  output logic                int_sts,
  output logic                wake_sts,
  output logic                irq,
  output logic [NUM_WAKE-1:0] wake_req,
  output logic                pending
);

  localparam logic [1:0] POL_HI   = 2'd0;
  localparam logic [1:0] POL_LO   = 2'd1;
  localparam logic [1:0] POL_BOTH = 2'd2;

  logic pin_q, ref_ok, rise, fall, trig, wake_any;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_q  <= 1'b0;
      ref_ok <= 1'b0;
    end else begin
      pin_q  <= pin_in;
      ref_ok <= 1'b1;
    end

  assign rise = ref_ok &  pin_in & ~pin_q;
  assign fall = ref_ok & ~pin_in &  pin_q;

  always_comb begin
    trig = 1'b0;
    if (lvl_mode) begin
      case (pol_sel)
        POL_HI:  trig =  pin_in;
        POL_LO:  trig = ~pin_in;
        default: trig = 1'b0;
      endcase
    end else begin
      case (pol_sel)
        POL_HI:   trig = rise;
        POL_LO:   trig = fall;
        POL_BOTH: trig = rise | fall;
        default:  trig = 1'b0;
      endcase
    end
  end

  assign wake_any = |wake_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      int_sts  <= 1'b0;
      wake_sts <= 1'b0;
    end else begin
      if (trig && int_en)    int_sts <= 1'b1;
      else if (int_clr)      int_sts <= 1'b0;
      if (trig && wake_any)  wake_sts <= 1'b1;
      else if (wake_clr)     wake_sts <= 1'b0;
    end

  assign irq      = int_sts & unmask;
  assign wake_req = {NUM_WAKE{wake_sts}} & wake_en;
  assign pending  = int_sts | wake_sts;

  a_r5_no_set_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_en && !int_sts) |=> !int_sts);
  a_r6_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (int_sts && !int_clr) |=> int_sts);
  a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (int_clr && !(int_en && trig)) |=> !int_sts);
  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en && trig) |=> int_sts);
  a_r4_code3_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_sel == 2'd3 && !int_sts) |=> !int_sts);
  a_r9_wake_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_clr && !(trig && wake_any)) |=> !wake_sts);

endmodule

// File: tb/gpio_pin_event_tb.sv
module gpio_pin_event_tb_top;
  logic clk = 0, rst_n = 0;
  logic pin_in = 0, lvl_mode = 0, int_en = 0, unmask = 0, int_clr = 0, wake_clr = 0;
  logic [1:0] pol_sel = 0;
  logic [2:0] wake_en = 0;
  logic int_sts, wake_sts, irq, pending;
  logic [2:0] wake_req;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  gpio_pin_event #(.NUM_WAKE(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .lvl_mode(lvl_mode), .pol_sel(pol_sel),
    .int_en(int_en), .unmask(unmask), .wake_en(wake_en), .int_clr(int_clr),
    .wake_clr(wake_clr), .int_sts(int_sts), .wake_sts(wake_sts), .irq(irq),
    .wake_req(wake_req), .pending(pending));

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_int();
    int_clr = 1; tick(); int_clr = 0;
  endtask

  task automatic t_reset();
    chk("R1 int_sts", int_sts, 0); chk("R1 wake_sts", wake_sts, 0);
    chk("R1 irq", irq, 0); chk("R1 pending", pending, 0); chk("R1 wake_req", wake_req, 0);
  endtask

  task automatic t_rise_fall();
    lvl_mode = 0; pol_sel = 0; int_en = 1; unmask = 1; pin_in = 0; tick(2);
    pin_in = 1; tick(); chk("R2 rise sets", int_sts, 1); chk("R6 irq", irq, 1);
    tick(2); chk("R6 sticky", int_sts, 1);
    clr_int(); chk("R7 clear", int_sts, 0);
    pin_in = 0; tick(); chk("R2 code0 ignores fall", int_sts, 0);
    pol_sel = 1; pin_in = 1; tick(); chk("R2 code1 ignores rise", int_sts, 0);
    pin_in = 0; tick(); chk("R2 fall sets", int_sts, 1); clr_int();
  endtask

  task automatic t_both();
    pol_sel = 2; pin_in = 1; tick(); chk("R3 rise", int_sts, 1); clr_int();
    pin_in = 0; tick(); chk("R3 fall", int_sts, 1); clr_int();
  endtask

  task automatic t_none();
    pol_sel = 3; pin_in = 1; tick(); pin_in = 0; tick(); chk("R4 code3 edge", int_sts, 0);
    lvl_mode = 1; pin_in = 1; tick(2); chk("R4 code3 level", int_sts, 0);
    pol_sel = 2; tick(2); pin_in = 0; tick(2); chk("R4 code2 level", int_sts, 0);
  endtask

  task automatic t_level();
    lvl_mode = 1; pol_sel = 0; pin_in = 1; tick(); chk("R8 high level", int_sts, 1);
    clr_int(); chk("R8 clear while active", int_sts, 1);
    pin_in = 0; tick(); clr_int(); chk("R8 clear after idle", int_sts, 0);
    pol_sel = 1; tick(); chk("R8 low level", int_sts, 1);
    pol_sel = 3; clr_int(); lvl_mode = 0; pol_sel = 0; tick();
  endtask

  task automatic t_disabled();
    int_en = 0; pin_in = 1; tick(); chk("R5 disabled", int_sts, 0);
    int_en = 1; tick(); chk("R5 no late set", int_sts, 0);
    pin_in = 0; tick();
  endtask

  task automatic t_mask();
    unmask = 0; pin_in = 1; tick(); chk("R6 sts masked", int_sts, 1); chk("R6 irq masked", irq, 0);
    unmask = 1; #1; chk("R6 irq unmasked", irq, 1); chk("R10 pending int", pending, 1);
    pin_in = 0; tick(); clr_int();
  endtask

  task automatic t_prio();
    pin_in = 1; tick(); pin_in = 0; tick(); chk("R7 setup", int_sts, 1);
    pin_in = 1; int_clr = 1; tick(); int_clr = 0; chk("R7 edge beats clear", int_sts, 1);
    clr_int(); chk("R7 later clear", int_sts, 0); pin_in = 0; tick();
  endtask

  task automatic t_wake();
    int_en = 0; wake_en = 3'b010; pin_in = 1; tick();
    chk("R9 wake set", wake_sts, 1); chk("R9 int off", int_sts, 0);
    chk("R9 wake_req", wake_req, 3'b010); chk("R10 pending wake", pending, 1);
    wake_en = 3'b101; #1; chk("R9 req follows en", wake_req, 3'b101);
    wake_clr = 1; tick(); wake_clr = 0;
    chk("R9 wake clear", wake_sts, 0); chk("R10 pending off", pending, 0);
    wake_en = 0; pin_in = 0; tick(); pin_in = 1; tick(); chk("R9 no enable", wake_sts, 0);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(2); t_reset(); rst_n = 1; tick();
    t_rise_fall(); t_both(); t_none(); t_level(); t_disabled(); t_mask(); t_prio(); t_wake();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule